// File: doc/BRIEF.md
# Windowed Watchdog Timer with Two-Stage Expiry

This block watches over software by counting strobes of a slow time base. If software does not service it before a programmable limit, the block requests a system reset. The limit is always a power of two: 2^(psel+1) strobes, where psel is a five-bit control field. Two strobe inputs are provided and a control bit picks one of them. A second control bit gates the count. The state of that gate can be read back, so software can confirm that a change has taken effect.

Two optional modes build on the basic timeout. In window mode, a service (a "kick") that comes too soon after the previous restart is treated as a fault and causes a reset request. "Too soon" means fewer than 2^(tban+1) strobes have passed. In interrupt mode, the first expiry only raises a flag and restarts the count. A reset is requested only if that flag is still set when the next expiry arrives. A kick restarts the counter after a short synchronising delay, and a status bit shows when that restart has completed.

The register bus is a plain single-cycle write port with a combinational read port. It runs on the same clock as the counter. The strobe inputs stand in for the slow clock.

Top module: `wdg_windowed`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0, the status word (0x08) reads 0x2 (restart-done = 1, window-open = 0), the mask (0x14) and flag (0x18) words read 0, and irq and rst_req are low.
- R2: When the control word has bit 0 (run) and bit 16 (gate) set and psel is in bits 12:8, rst_req goes high exactly 2^(psel+1) cycles of an always-high strobe after the enabling write. It stays high for one cycle, and the counter restarts from zero.
- R3: If control bit 1 (auto-stop) is set, a reset request clears the run bit. If it is clear, the run bit stays set and the timeout repeats with the same period.
- R4: A write to the kick word (0x04) with bit 0 = 1 restarts the counter two cycles later. Status bit 1 reads 0 during those two cycles. A kick with bit 0 = 0, or one that arrives while a restart is still pending, has no effect.
- R5: With control bit 2 (window) set and tban in bits 22:18, a kick made while the count is below 2^(tban+1) raises rst_req in the next cycle and restarts the counter. Status bit 0 reads 1 exactly when the count has reached 2^(tban+1).
- R6: With control bit 4 (two-stage) set, the first expiry sets flag bit 2 (offset 0x18) and restarts the count without a reset request. An expiry that finds the flag still set raises rst_req. Every reset request clears the flag.
- R7: Writing bit 2 = 1 to the flag-clear word (0x1C) clears the flag. An expiry in the same cycle takes priority and leaves the flag set.
- R8: Writing bit 2 = 1 to 0x0C sets the interrupt mask, and writing bit 2 = 1 to 0x10 clears it. Bit 2 of 0x14 reads the mask. irq is high exactly when both the flag and the mask are set.
- R9: Control bit 16 reads back the applied gate state, which follows a write one cycle later. While the gate is off, the counter does not advance.
- R10: Control bit 17 selects the strobe: 0 selects tick_a and 1 selects tick_b. The unselected strobe has no effect on the count.
- R11: While the run bit is clear, the counter is held at zero and no reset request occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count strobe, source 0 |
| tick_b | input | 1 | Count strobe, source 1 |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | Masked expiry-flag interrupt |
| rst_req | output | 1 | One-cycle reset-request pulse |

## Verification
The assertions assume that the control word is not rewritten in the same cycle as an expiry or a fault. They also assume that a kick is never written in the cycle right after a window fault, because each such kick would be a separate one-cycle request. The bench keeps within these limits by rearming the block before each trial: it stops the counter, lets pending restarts drain, clears the flag, and then starts the counter again. Each kick is placed at a known count, measured from that restart. Sweeps cover psel 0 to 4 and tban 0 to 2 against every kick position below the limit.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam int unsigned SEL_W  = 5;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned ADDR_W = 5;

   // control word bit positions
   localparam int unsigned C_RUN   = 0;
   localparam int unsigned C_STOP  = 1;
   localparam int unsigned C_WIN   = 2;
   localparam int unsigned C_TWO   = 4;
   localparam int unsigned C_PSEL  = 8;
   localparam int unsigned C_GATE  = 16;
   localparam int unsigned C_SRC   = 17;
   localparam int unsigned C_TBAN  = 18;

   // other bit positions
   localparam int unsigned K_GO    = 0;
   localparam int unsigned F_EXP   = 2;
   localparam int unsigned S_OPEN  = 0;
   localparam int unsigned S_DONE  = 1;

   typedef enum logic [2:0] {
      RI_CTL     = 3'd0,
      RI_KICK    = 3'd1,
      RI_STAT    = 3'd2,
      RI_MSET    = 3'd3,
      RI_MCLR    = 3'd4,
      RI_MASK    = 3'd5,
      RI_FLAG    = 3'd6,
      RI_FCLR    = 3'd7
   } reg_idx_e;

   typedef struct packed {
      logic             run;
      logic             stop;
      logic             win;
      logic             two;
      logic [SEL_W-1:0] psel;
      logic             gate;
      logic             src;
      logic [SEL_W-1:0] tban;
   } ctl_t;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              fatal,
   input  logic              flag,
   input  logic              win_open,
   input  logic              kick_busy,
   output ctl_t              ctl,
   output logic              gate_ack,
   output logic              kick_req,
   output logic              flag_clr,
   output logic              irq
);

   reg_idx_e idx;
   logic     mask;
   logic     unused_bits;

   assign idx      = reg_idx_e'(bus_addr[4:2]);
   assign kick_req = bus_we && (idx == RI_KICK) && bus_wdata[K_GO];
   assign flag_clr = bus_we && (idx == RI_FCLR) && bus_wdata[F_EXP];
   assign irq      = flag & mask;

   assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:23], bus_wdata[15:13],
                          bus_wdata[7:5], bus_wdata[3]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else begin
         if (bus_we && idx == RI_CTL) begin
            ctl.run  <= bus_wdata[C_RUN];
            ctl.stop <= bus_wdata[C_STOP];
            ctl.win  <= bus_wdata[C_WIN];
            ctl.two  <= bus_wdata[C_TWO];
            ctl.psel <= bus_wdata[C_PSEL +: SEL_W];
            ctl.gate <= bus_wdata[C_GATE];
            ctl.src  <= bus_wdata[C_SRC];
            ctl.tban <= bus_wdata[C_TBAN +: SEL_W];
         end
         if (fatal && ctl.stop) ctl.run <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_ack <= 1'b0;
         mask     <= 1'b0;
      end else begin
         gate_ack <= ctl.gate;
         if (bus_we && idx == RI_MSET && bus_wdata[F_EXP]) mask <= 1'b1;
         else if (bus_we && idx == RI_MCLR && bus_wdata[F_EXP]) mask <= 1'b0;
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (idx)
         RI_CTL: begin
            bus_rdata[C_RUN]             = ctl.run;
            bus_rdata[C_STOP]            = ctl.stop;
            bus_rdata[C_WIN]             = ctl.win;
            bus_rdata[C_TWO]             = ctl.two;
            bus_rdata[C_PSEL +: SEL_W]   = ctl.psel;
            bus_rdata[C_GATE]            = gate_ack;
            bus_rdata[C_SRC]             = ctl.src;
            bus_rdata[C_TBAN +: SEL_W]   = ctl.tban;
         end
         RI_STAT: begin
            bus_rdata[S_OPEN] = win_open;
            bus_rdata[S_DONE] = ~kick_busy;
         end
         RI_MASK: bus_rdata[F_EXP] = mask;
         RI_FLAG: bus_rdata[F_EXP] = flag;
         default: bus_rdata = '0;
      endcase
   end

   // R3
   stop_clears_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fatal && ctl.stop) |=> !ctl.run);

endmodule

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick_req,
   input  logic cancel,
   output logic busy,
   output logic restart
);

   logic [STAGES-1:0] pipe;
   logic              load;

   assign load    = kick_req & ~busy & ~cancel;
   assign busy    = |pipe;
   assign restart = pipe[STAGES-1];

   if (STAGES < 1) begin : g_bad_stages
      $error("wdg_kick_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= load;
      end
   end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '0;
         else        pipe <= {pipe[STAGES-2:0], load};
      end
   end

   // R4
   kick_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy);

endmodule

// File: rtl/wdg_core.sv
module wdg_core
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_a,
   input  logic             tick_b,
   input  logic             run,
   input  logic             win,
   input  logic             two,
   input  logic             src,
   input  logic [SEL_W-1:0] psel,
   input  logic [SEL_W-1:0] tban,
   input  logic             gate_ack,
   input  logic             kick_req,
   input  logic             kick_busy,
   input  logic             restart,
   input  logic             flag_clr,
   output logic             early,
   output logic             fatal,
   output logic             flag,
   output logic             win_open,
   output logic             rst_req
);

   localparam int unsigned LIM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt;
   logic [LIM_W-1:0] cnt_x;
   logic [LIM_W-1:0] lim;
   logic [LIM_W-1:0] ban;
   logic             tick;
   logic             adv;
   logic             at_end;

   assign tick     = src ? tick_b : tick_a;
   assign adv      = run & gate_ack & tick;
   assign cnt_x    = {1'b0, cnt};
   assign lim      = LIM_W'(1) << (int'(psel) + 1);
   assign ban      = LIM_W'(1) << (int'(tban) + 1);
   assign at_end   = adv && !restart && (cnt_x + LIM_W'(1) == lim);
   assign early    = kick_req && !kick_busy && run && win && (cnt_x < ban);
   assign fatal    = early | (at_end & (~two | flag));
   assign win_open = cnt_x >= ban;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 cnt <= '0;
      else if (!run || fatal || restart || at_end) cnt <= '0;
      else if (adv)                               cnt <= cnt + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag    <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fatal;
         if (fatal)              flag <= 1'b0;
         else if (at_end && two) flag <= 1'b1;
         else if (flag_clr)      flag <= 1'b0;
      end
   end

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (cnt == '0));

   // R2
   timeout_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !two) |=> (rst_req && cnt == '0));

   // R5
   early_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early |=> (rst_req && cnt == '0));

   // R6
   first_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && two && !flag && !early) |=> (flag && !rst_req));

   // R4
   restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt == '0));

endmodule

// File: rtl/wdg_windowed.sv
module wdg_windowed
   import wdg_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_a,
   input  logic              tick_b,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              rst_req
);

   if ((1 << SEL_W) > CNT_W) begin : g_bad_cnt
      $error("wdg_windowed: CNT_W too narrow for the largest prescale");
   end

   ctl_t ctl;
   logic gate_ack, kick_req, flag_clr, kick_busy, restart;
   logic early, fatal, flag, win_open;

   wdg_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .fatal     (fatal),
      .flag      (flag),
      .win_open  (win_open),
      .kick_busy (kick_busy),
      .ctl       (ctl),
      .gate_ack  (gate_ack),
      .kick_req  (kick_req),
      .flag_clr  (flag_clr),
      .irq       (irq)
   );

   wdg_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .kick_req (kick_req),
      .cancel   (early),
      .busy     (kick_busy),
      .restart  (restart)
   );

   wdg_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_a    (tick_a),
      .tick_b    (tick_b),
      .run       (ctl.run),
      .win       (ctl.win),
      .two       (ctl.two),
      .src       (ctl.src),
      .psel      (ctl.psel),
      .tban      (ctl.tban),
      .gate_ack  (gate_ack),
      .kick_req  (kick_req),
      .kick_busy (kick_busy),
      .restart   (restart),
      .flag_clr  (flag_clr),
      .early     (early),
      .fatal     (fatal),
      .flag      (flag),
      .win_open  (win_open),
      .rst_req   (rst_req)
   );

   // R8
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> flag);

endmodule

// File: tb/wdg_windowed_tb.sv
module wdg_windowed_tb;

   localparam int A_CTL = 5'h00, A_KICK = 5'h04, A_STAT = 5'h08, A_MSET = 5'h0C;
   localparam int A_MCLR = 5'h10, A_MASK = 5'h14, A_FLAG = 5'h18, A_FCLR = 5'h1C;
   localparam int RUN = 1, STOP = 2, WIN = 4, TWO = 16, GATE = 1 << 16, SRC = 1 << 17;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_a = 1'b1;
   logic        tick_b = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, rst_req;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   wdg_windowed u_dut (
      .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input int a, input int d);
      bus_we    = 1'b1;
      bus_addr  = 5'(a);
      bus_wdata = 32'(d);
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      bus_addr = 5'(a);
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic wait_rst(input int max, output int j);
      j = 0;
      while (!rst_req && j < max) begin
         idle(1);
         j++;
      end
   endtask

   task automatic arm(input int cfg);
      wr(A_CTL, cfg & ~RUN);
      idle(2);
      wr(A_FCLR, 4);
      wr(A_CTL, cfg | RUN);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      int v, j, len;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTL, v);  chk("R1 control word", v, 0);
      rd(A_STAT, v); chk("R1 status word", v, 2);
      rd(A_MASK, v); chk("R1 mask word", v, 0);
      rd(A_FLAG, v); chk("R1 flag word", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 rst_req", int'(rst_req), 0);

      // R2 / R3 / R11 timeout sweep
      for (int p = 0; p < 5; p++) begin
         len = 2 << p;
         arm(GATE | (p << 8));
         wait_rst(4 * len, j);
         chk("R2 timeout length", j, len);
         idle(1);
         chk("R2 pulse width", int'(rst_req), 0);
         wait_rst(4 * len, j);
         chk("R3 repeat period", j, len - 1);
         rd(A_CTL, v);
         chk("R3 run kept", v & 1, 1);

         arm(GATE | STOP | (p << 8));
         wait_rst(4 * len, j);
         chk("R2 timeout with auto-stop", j, len);
         rd(A_CTL, v);
         chk("R3 run cleared", v & 1, 0);
         idle(1);
         wait_rst(3 * len, j);
         chk("R11 no request while stopped", j, 3 * len);
      end

      // R4 kick restart and done flag
      len = 16;
      arm(GATE | (3 << 8));
      idle(4);
      wr(A_KICK, 1);
      rd(A_STAT, v); chk("R4 done low 1st cycle", (v >> 1) & 1, 0);
      idle(1);
      rd(A_STAT, v); chk("R4 done low 2nd cycle", (v >> 1) & 1, 0);
      idle(1);
      rd(A_STAT, v); chk("R4 done high", (v >> 1) & 1, 1);
      wait_rst(4 * len, j);
      chk("R4 restart timing", j, len);

      arm(GATE | (3 << 8));
      idle(4);
      wr(A_KICK, 1);
      wr(A_KICK, 1);
      wait_rst(4 * len, j);
      chk("R4 kick while pending ignored", j, len + 1);

      arm(GATE | (3 << 8));
      idle(4);
      wr(A_KICK, 0);
      wait_rst(4 * len, j);
      chk("R4 kick with bit0 clear ignored", j, len - 5);

      // R5 window sweep
      for (int t = 0; t < 3; t++) begin
         for (int d = 0; d < 11; d++) begin
            arm(GATE | WIN | (3 << 8) | (t << 18));
            idle(d);
            rd(A_STAT, v);
            chk("R5 window-open bit", v & 1, (d >= (2 << t)) ? 1 : 0);
            wr(A_KICK, 1);
            chk("R5 early kick request", int'(rst_req), (d < (2 << t)) ? 1 : 0);
         end
      end
      arm(GATE | (3 << 8) | (2 << 18));
      idle(1);
      wr(A_KICK, 1);
      chk("R5 no fault outside window mode", int'(rst_req), 0);

      // R6 / R8 two-stage expiry
      len = 8;
      wr(A_MSET, 4);
      arm(GATE | TWO | (2 << 8));
      idle(len);
      chk("R6 irq on first expiry", int'(irq), 1);
      chk("R6 no request on first expiry", int'(rst_req), 0);
      rd(A_FLAG, v); chk("R6 flag set", v, 4);
      wait_rst(4 * len, j);
      chk("R6 second expiry request", j, len);
      rd(A_FLAG, v); chk("R6 flag cleared by request", v, 0);

      // R7 flag clear
      arm(GATE | TWO | (2 << 8));
      idle(len);
      wr(A_FCLR, 4);
      chk("R7 irq after clear", int'(irq), 0);
      idle(len - 1);
      chk("R7 no request after clear", int'(rst_req), 0);
      chk("R7 flag set again", int'(irq), 1);

      // R8 mask
      wr(A_MCLR, 4);
      rd(A_MASK, v); chk("R8 mask cleared", v, 0);
      chk("R8 irq masked", int'(irq), 0);
      rd(A_FLAG, v); chk("R8 flag kept under mask", v, 4);
      wr(A_MSET, 4);
      rd(A_MASK, v); chk("R8 mask set", v, 4);
      chk("R8 irq unmasked", int'(irq), 1);

      // R9 gate readback and freeze
      wr(A_CTL, 0);
      idle(2);
      wr(A_CTL, GATE);
      rd(A_CTL, v); chk("R9 gate readback delayed", (v >> 16) & 1, 0);
      idle(1);
      rd(A_CTL, v); chk("R9 gate readback applied", (v >> 16) & 1, 1);
      arm(0);
      wait_rst(40, j);
      chk("R9 counter frozen with gate off", j, 40);

      // R10 source select
      tick_b = 1'b0;
      arm(GATE | SRC);
      wait_rst(40, j);
      chk("R10 idle source b stops count", j, 40);
      tick_b = 1'b1;
      tick_a = 1'b0;
      arm(GATE | SRC);
      wait_rst(40, j);
      chk("R10 source b counts", j, 2);
      arm(GATE);
      wait_rst(40, j);
      chk("R10 source a idle", j, 40);
      tick_a = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule